// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Controller

This block decides, every cycle, how operands reach the execute and memory stages of a scalar, in-order, five-stage pipeline (fetch, decode, execute, memory, writeback). It reads decoded register numbers and flags from the four inter-stage latches. It then drives the operand bypass multiplexer selects, the store-data bypass select, and the pipeline sequencing controls: stall, program-counter write enable, fetch/decode latch write enable, and the nop-insertion controls for the two front latches.

The controller is purely combinational. The pipeline's own latches register its outputs at the next clock edge. Forwarding favours the youngest producer. A load whose result is needed by the very next instruction holds the front of the pipe for one slot. The exception is a following store that wants the loaded value only as its data; the store-data bypass covers that case. A taken branch resolved in execute discards the two younger instructions. This takes precedence over any load-use hold in the same cycle.

Top module: `hazard_bypass_ctrl`

## Requirements
- R1: `alu_a_sel` selects the source for the execute operand taken from `dx_rs1`, encoded 0 = register file, 1 = execute/memory latch result, 2 = memory/writeback value (3 is never produced). It is 1 when the execute/memory latch's destination matches. Otherwise it is 2 when the memory/writeback latch's destination matches. Otherwise it is 0.
- R2: `alu_b_sel` follows the same encoding and priority for `dx_rs2`, independently of `alu_a_sel`.
- R3: A producer latch counts as a match only when its register-write enable is 1 and its destination register is not register 0. This applies to both operand selects, the store-data select and the load-use hold.
- R4: `st_data_sel` is 1 when the execute/memory latch holds a store (`xm_is_store` = 1) whose data register `xm_rs2` matches the memory/writeback destination. Otherwise it is 0.
- R5: With no taken branch, `stall` is 1 when the decode/execute latch holds a load (`dx_is_load` = 1) whose destination matches `fd_rs1`.
- R6: A load destination matching `fd_rs2` raises `stall` only when the fetch/decode instruction is not a store (`fd_is_store` = 0).
- R7: While `stall` is 1: `pc_we` = 0, `fd_we` = 0, `dx_nop` = 1 and `fd_flush` = 0.
- R8: With no hold and no taken branch: `pc_we` = 1, `fd_we` = 1, `dx_nop` = 0 and `fd_flush` = 0.
- R9: When `br_taken_x` = 1: `fd_flush` = 1, `dx_nop` = 1, `pc_we` = 1, `fd_we` = 1 and `stall` = 0, even if a load-use condition is present.
- R10: A matching destination in the decode/execute latch raises no `stall` unless that instruction is a load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fd_rs1 | input | AW | First source register of the fetch/decode instruction |
| fd_rs2 | input | AW | Second source register of the fetch/decode instruction |
| fd_is_store | input | 1 | Fetch/decode instruction is a store |
| dx_rs1 | input | AW | First source register of the decode/execute instruction |
| dx_rs2 | input | AW | Second source register of the decode/execute instruction |
| dx_rd | input | AW | Destination register of the decode/execute instruction |
| dx_wen | input | 1 | Decode/execute instruction writes a register |
| dx_is_load | input | 1 | Decode/execute instruction is a load |
| xm_rd | input | AW | Destination register of the execute/memory instruction |
| xm_wen | input | 1 | Execute/memory instruction writes a register |
| xm_rs2 | input | AW | Store-data register of the execute/memory instruction |
| xm_is_store | input | 1 | Execute/memory instruction is a store |
| mw_rd | input | AW | Destination register of the memory/writeback instruction |
| mw_wen | input | 1 | Memory/writeback instruction writes a register |
| br_taken_x | input | 1 | Branch in execute resolved taken |
| alu_a_sel | output | 2 | Operand A bypass select |
| alu_b_sel | output | 2 | Operand B bypass select |
| st_data_sel | output | 1 | Store-data select: 1 = writeback value, 0 = latched data |
| stall | output | 1 | Load-use hold of the front of the pipe |
| pc_we | output | 1 | Program counter write enable |
| fd_we | output | 1 | Fetch/decode latch write enable |
| fd_flush | output | 1 | Load a nop into the fetch/decode latch |
| dx_nop | output | 1 | Load a nop with cleared controls into the decode/execute latch |

## Verification
The bench builds the controller with AW = 3, so the register space has only eight entries. With that width, random register numbers collide across stages on most cycles, and register 0 turns up about one time in eight. Double matches, where both producers name the same register, become common enough to exercise the priority rule, and zero-register suppression gets regular coverage. Load-use holds, store exemptions and simultaneous taken branches arise often in the random sweep. Directed scenarios pin down each corner before the sweep starts.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

  // Operand source encoding shared by both ALU bypass muxes.
  typedef enum logic [1:0] {
    SRC_RF = 2'd0,
    SRC_XM = 2'd1,
    SRC_MW = 2'd2
  } opnd_src_e;

  // Sequencing controls for the front of the pipe.
  typedef struct packed {
    logic stall;
    logic pc_we;
    logic fd_we;
    logic fd_flush;
    logic dx_nop;
  } seq_ctl_t;

  localparam int unsigned NUM_ALU_OPNDS = 2;

endpackage

// File: rtl/hbc_operand_fwd.sv
module hbc_operand_fwd
  import hbc_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic          xm_wen,
  input  logic [AW-1:0] xm_rd,
  input  logic          mw_wen,
  input  logic [AW-1:0] mw_rd,
  output opnd_src_e     sel,
  output logic          xm_hit,
  output logic          mw_hit
);

  function automatic logic producer_hit(input logic wen,
                                        input logic [AW-1:0] rd,
                                        input logic [AW-1:0] rs);
    return wen && (rd != '0) && (rd == rs);
  endfunction

  assign xm_hit = producer_hit(xm_wen, xm_rd, src);
  assign mw_hit = producer_hit(mw_wen, mw_rd, src);

  // Younger producer (execute/memory) wins over older one.
  always_comb begin
    if (xm_hit)      sel = SRC_XM;
    else if (mw_hit) sel = SRC_MW;
    else             sel = SRC_RF;
  end

endmodule

// File: rtl/hbc_store_fwd.sv
module hbc_store_fwd #(
  parameter int unsigned AW = 5
) (
  input  logic          xm_is_store,
  input  logic [AW-1:0] xm_rs2,
  input  logic          mw_wen,
  input  logic [AW-1:0] mw_rd,
  output logic          sel
);

  function automatic logic wb_feeds_store(input logic st,
                                          input logic [AW-1:0] data_reg,
                                          input logic wen,
                                          input logic [AW-1:0] rd);
    return st && wen && (rd != '0) && (rd == data_reg);
  endfunction

  // Feeds only the store-data input; the address path never uses it.
  assign sel = wb_feeds_store(xm_is_store, xm_rs2, mw_wen, mw_rd);

endmodule

// File: rtl/hbc_loaduse.sv
module hbc_loaduse #(
  parameter int unsigned AW = 5
) (
  input  logic          dx_is_load,
  input  logic          dx_wen,
  input  logic [AW-1:0] dx_rd,
  input  logic [AW-1:0] fd_rs1,
  input  logic [AW-1:0] fd_rs2,
  input  logic          fd_is_store,
  output logic          rs1_dep,
  output logic          rs2_dep,
  output logic          hit
);

  function automatic logic load_feeds(input logic ld,
                                      input logic wen,
                                      input logic [AW-1:0] rd,
                                      input logic [AW-1:0] rs);
    return ld && wen && (rd != '0) && (rd == rs);
  endfunction

  assign rs1_dep = load_feeds(dx_is_load, dx_wen, dx_rd, fd_rs1);
  // A store that wants the load only as data is served by the store-data bypass.
  assign rs2_dep = load_feeds(dx_is_load, dx_wen, dx_rd, fd_rs2) && !fd_is_store;
  assign hit     = rs1_dep || rs2_dep;

endmodule

// File: rtl/hbc_seq_ctl.sv
module hbc_seq_ctl
  import hbc_pkg::*;
(
  input  logic     loaduse_hit,
  input  logic     br_taken,
  output seq_ctl_t ctl
);

  always_comb begin
    ctl = '{stall: 1'b0, pc_we: 1'b1, fd_we: 1'b1, fd_flush: 1'b0, dx_nop: 1'b0};
    if (br_taken) begin
      // Redirect: both younger slots become nops, PC loads the target.
      ctl.fd_flush = 1'b1;
      ctl.dx_nop   = 1'b1;
    end else if (loaduse_hit) begin
      ctl.stall  = 1'b1;
      ctl.pc_we  = 1'b0;
      ctl.fd_we  = 1'b0;
      ctl.dx_nop = 1'b1;
    end
  end

endmodule

// File: rtl/hazard_bypass_ctrl.sv
module hazard_bypass_ctrl
  import hbc_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] fd_rs1,
  input  logic [AW-1:0] fd_rs2,
  input  logic          fd_is_store,
  input  logic [AW-1:0] dx_rs1,
  input  logic [AW-1:0] dx_rs2,
  input  logic [AW-1:0] dx_rd,
  input  logic          dx_wen,
  input  logic          dx_is_load,
  input  logic [AW-1:0] xm_rd,
  input  logic          xm_wen,
  input  logic [AW-1:0] xm_rs2,
  input  logic          xm_is_store,
  input  logic [AW-1:0] mw_rd,
  input  logic          mw_wen,
  input  logic          br_taken_x,
  output logic [1:0]    alu_a_sel,
  output logic [1:0]    alu_b_sel,
  output logic          st_data_sel,
  output logic          stall,
  output logic          pc_we,
  output logic          fd_we,
  output logic          fd_flush,
  output logic          dx_nop
);

  localparam int unsigned NOP = NUM_ALU_OPNDS;

  logic [NOP-1:0][AW-1:0] opnd_src;
  opnd_src_e              opnd_sel  [NOP];
  logic [NOP-1:0]         opnd_xm_hit;
  logic [NOP-1:0]         opnd_mw_hit;

  // Named internal events, visible to the bound checker.
  logic     loaduse_hit;
  logic     loaduse_rs1;
  logic     loaduse_rs2;
  logic     flush_evt;
  seq_ctl_t seq;

  assign opnd_src[0] = dx_rs1;
  assign opnd_src[1] = dx_rs2;

  for (genvar g = 0; g < NOP; g++) begin : g_opnd
    hbc_operand_fwd #(.AW(AW)) u_fwd (
      .src    (opnd_src[g]),
      .xm_wen (xm_wen),
      .xm_rd  (xm_rd),
      .mw_wen (mw_wen),
      .mw_rd  (mw_rd),
      .sel    (opnd_sel[g]),
      .xm_hit (opnd_xm_hit[g]),
      .mw_hit (opnd_mw_hit[g])
    );
  end

  assign alu_a_sel = opnd_sel[0];
  assign alu_b_sel = opnd_sel[1];

  hbc_store_fwd #(.AW(AW)) u_st_fwd (
    .xm_is_store (xm_is_store),
    .xm_rs2      (xm_rs2),
    .mw_wen      (mw_wen),
    .mw_rd       (mw_rd),
    .sel         (st_data_sel)
  );

  hbc_loaduse #(.AW(AW)) u_loaduse (
    .dx_is_load  (dx_is_load),
    .dx_wen      (dx_wen),
    .dx_rd       (dx_rd),
    .fd_rs1      (fd_rs1),
    .fd_rs2      (fd_rs2),
    .fd_is_store (fd_is_store),
    .rs1_dep     (loaduse_rs1),
    .rs2_dep     (loaduse_rs2),
    .hit         (loaduse_hit)
  );

  assign flush_evt = br_taken_x;

  hbc_seq_ctl u_seq (
    .loaduse_hit (loaduse_hit),
    .br_taken    (flush_evt),
    .ctl         (seq)
  );

  assign stall    = seq.stall;
  assign pc_we    = seq.pc_we;
  assign fd_we    = seq.fd_we;
  assign fd_flush = seq.fd_flush;
  assign dx_nop   = seq.dx_nop;

endmodule

// File: rtl/hbc_checker.sv
module hbc_checker #(
  parameter int unsigned AW = 5
) (
  input logic [AW-1:0] dx_rs1,
  input logic [AW-1:0] dx_rs2,
  input logic [AW-1:0] dx_rd,
  input logic          dx_is_load,
  input logic [AW-1:0] xm_rd,
  input logic          xm_wen,
  input logic [AW-1:0] xm_rs2,
  input logic          xm_is_store,
  input logic [AW-1:0] mw_rd,
  input logic          mw_wen,
  input logic          br_taken_x,
  input logic [1:0]    alu_a_sel,
  input logic [1:0]    alu_b_sel,
  input logic          st_data_sel,
  input logic          stall,
  input logic          pc_we,
  input logic          fd_we,
  input logic          fd_flush,
  input logic          dx_nop,
  input logic          loaduse_hit
);

  always_comb begin
    // R1
    a_sel_xm_chk: assert (alu_a_sel != 2'd1 || (xm_wen && xm_rd == dx_rs1))
      else $error("operand A took X/M without a matching producer");
    // R1
    a_sel_legal_chk: assert (alu_a_sel != 2'd3)
      else $error("operand A select out of range");
    // R2
    b_sel_xm_chk: assert (alu_b_sel != 2'd1 || (xm_wen && xm_rd == dx_rs2))
      else $error("operand B took X/M without a matching producer");
    // R3
    mw_nonzero_chk: assert (alu_a_sel != 2'd2 || (mw_wen && mw_rd != '0))
      else $error("operand A took M/W from register 0 or a non-writer");
    // R4
    st_data_src_chk: assert (!st_data_sel || (xm_is_store && mw_wen && mw_rd == xm_rs2))
      else $error("store-data bypass without a store consumer");
    // R7
    stall_hold_chk: assert (!stall || (!pc_we && !fd_we && dx_nop && !fd_flush))
      else $error("stall did not hold the front of the pipe");
    // R9
    flush_pair_chk: assert (!br_taken_x || (fd_flush && dx_nop && pc_we && !stall))
      else $error("taken branch did not squash both younger slots");
    // R10
    stall_load_chk: assert (!stall || (dx_is_load && loaduse_hit && dx_rd != '0))
      else $error("stall without a load producer");
  end

endmodule

bind hazard_bypass_ctrl hbc_checker #(.AW(AW)) u_hbc_checker (
  .dx_rs1      (dx_rs1),
  .dx_rs2      (dx_rs2),
  .dx_rd       (dx_rd),
  .dx_is_load  (dx_is_load),
  .xm_rd       (xm_rd),
  .xm_wen      (xm_wen),
  .xm_rs2      (xm_rs2),
  .xm_is_store (xm_is_store),
  .mw_rd       (mw_rd),
  .mw_wen      (mw_wen),
  .br_taken_x  (br_taken_x),
  .alu_a_sel   (alu_a_sel),
  .alu_b_sel   (alu_b_sel),
  .st_data_sel (st_data_sel),
  .stall       (stall),
  .pc_we       (pc_we),
  .fd_we       (fd_we),
  .fd_flush    (fd_flush),
  .dx_nop      (dx_nop),
  .loaduse_hit (loaduse_hit)
);

// File: tb/hazard_bypass_ctrl_bench.sv
module hazard_bypass_ctrl_bench;

  localparam int unsigned AW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [AW-1:0] fd_rs1, fd_rs2, dx_rs1, dx_rs2, dx_rd, xm_rd, xm_rs2, mw_rd;
  logic fd_is_store, dx_wen, dx_is_load, xm_wen, xm_is_store, mw_wen, br_taken_x;
  logic [1:0] alu_a_sel, alu_b_sel;
  logic st_data_sel, stall, pc_we, fd_we, fd_flush, dx_nop;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  hazard_bypass_ctrl #(.AW(AW)) u_hazard_bypass_ctrl (.*);

  task automatic cmp(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_inputs();
    {fd_rs1, fd_rs2, dx_rs1, dx_rs2, dx_rd, xm_rd, xm_rs2, mw_rd} = '0;
    {fd_is_store, dx_wen, dx_is_load, xm_wen, xm_is_store, mw_wen, br_taken_x} = '0;
  endtask

  // Inputs change just after a falling edge; outputs are read 2 ns later.
  task automatic settle();
    #2;
  endtask

  task automatic next_slot();
    @(negedge clk);
    #1;
  endtask

  // Independent reference for one bypass select.
  function automatic int ref_sel(input logic [AW-1:0] rs);
    int r;
    r = 0;
    if (mw_wen && mw_rd != 0 && mw_rd == rs) r = 2;
    if (xm_wen && xm_rd != 0 && xm_rd == rs) r = 1;
    return r;
  endfunction

  task automatic check_all(input string req);
    bit lu, br;
    lu = dx_is_load && dx_wen && dx_rd != 0 &&
         (dx_rd == fd_rs1 || (dx_rd == fd_rs2 && !fd_is_store));
    br = br_taken_x;
    cmp(req, "alu_a_sel", alu_a_sel, ref_sel(dx_rs1));
    cmp(req, "alu_b_sel", alu_b_sel, ref_sel(dx_rs2));
    cmp(req, "st_data_sel", st_data_sel,
        int'(xm_is_store && mw_wen && mw_rd != 0 && mw_rd == xm_rs2));
    cmp(req, "stall", stall, int'(lu && !br));
    cmp(req, "pc_we", pc_we, int'(br || !lu));
    cmp(req, "fd_we", fd_we, int'(br || !lu));
    cmp(req, "fd_flush", fd_flush, int'(br));
    cmp(req, "dx_nop", dx_nop, int'(br || lu));
  endtask

  task automatic t_reset_state();
    clear_inputs(); settle();
    // R8: quiet pipe
    cmp("R8", "stall", stall, 0);
    cmp("R8", "pc_we", pc_we, 1);
    cmp("R8", "fd_we", fd_we, 1);
    cmp("R8", "fd_flush", fd_flush, 0);
    cmp("R8", "dx_nop", dx_nop, 0);
    cmp("R1", "alu_a_sel", alu_a_sel, 0);
  endtask

  task automatic t_opnd_a_priority();
    next_slot(); clear_inputs();
    dx_rs1 = 3; xm_rd = 3; xm_wen = 1; mw_rd = 3; mw_wen = 1; settle();
    cmp("R1", "alu_a_sel both match", alu_a_sel, 1);
    xm_wen = 0; settle();
    cmp("R1", "alu_a_sel mw only", alu_a_sel, 2);
    mw_rd = 4; settle();
    cmp("R1", "alu_a_sel none", alu_a_sel, 0);
  endtask

  task automatic t_opnd_b_indep();
    next_slot(); clear_inputs();
    dx_rs1 = 6; dx_rs2 = 5; xm_rd = 5; xm_wen = 1; mw_rd = 6; mw_wen = 1; settle();
    cmp("R2", "alu_b_sel", alu_b_sel, 1);
    cmp("R2", "alu_a_sel", alu_a_sel, 2);
  endtask

  task automatic t_zero_reg();
    next_slot(); clear_inputs();
    dx_rs1 = 0; dx_rs2 = 0; xm_wen = 1; mw_wen = 1; settle();
    cmp("R3", "alu_a_sel r0", alu_a_sel, 0);
    cmp("R3", "alu_b_sel r0", alu_b_sel, 0);
    dx_rs2 = 2; mw_rd = 2; mw_wen = 0; settle();
    cmp("R3", "alu_b_sel no wen", alu_b_sel, 0);
    dx_is_load = 1; dx_wen = 1; dx_rd = 0; fd_rs1 = 0; settle();
    cmp("R3", "stall on r0 load", stall, 0);
  endtask

  task automatic t_store_data();
    next_slot(); clear_inputs();
    xm_is_store = 1; xm_rs2 = 2; mw_rd = 2; mw_wen = 1; settle();
    cmp("R4", "st_data_sel match", st_data_sel, 1);
    mw_wen = 0; settle();
    cmp("R4", "st_data_sel no wen", st_data_sel, 0);
    mw_wen = 1; xm_is_store = 0; settle();
    cmp("R4", "st_data_sel non-store", st_data_sel, 0);
    xm_is_store = 1; xm_rs2 = 0; mw_rd = 0; settle();
    cmp("R4", "st_data_sel r0", st_data_sel, 0);
  endtask

  task automatic t_loaduse_rs1();
    next_slot(); clear_inputs();
    dx_is_load = 1; dx_wen = 1; dx_rd = 4; fd_rs1 = 4; fd_is_store = 1; settle();
    cmp("R5", "stall rs1", stall, 1);
    // R7: hold behaviour
    cmp("R7", "pc_we", pc_we, 0);
    cmp("R7", "fd_we", fd_we, 0);
    cmp("R7", "dx_nop", dx_nop, 1);
    cmp("R7", "fd_flush", fd_flush, 0);
  endtask

  task automatic t_loaduse_rs2();
    next_slot(); clear_inputs();
    dx_is_load = 1; dx_wen = 1; dx_rd = 4; fd_rs1 = 1; fd_rs2 = 4; fd_is_store = 1; settle();
    cmp("R6", "stall store data", stall, 0);
    cmp("R6", "pc_we store data", pc_we, 1);
    fd_is_store = 0; settle();
    cmp("R6", "stall non-store", stall, 1);
  endtask

  task automatic t_nonload();
    next_slot(); clear_inputs();
    dx_is_load = 0; dx_wen = 1; dx_rd = 5; fd_rs1 = 5; fd_rs2 = 5; settle();
    cmp("R10", "stall alu producer", stall, 0);
    cmp("R10", "dx_nop", dx_nop, 0);
  endtask

  task automatic t_branch();
    next_slot(); clear_inputs();
    br_taken_x = 1; dx_is_load = 1; dx_wen = 1; dx_rd = 7; fd_rs1 = 7; settle();
    cmp("R9", "stall", stall, 0);
    cmp("R9", "fd_flush", fd_flush, 1);
    cmp("R9", "dx_nop", dx_nop, 1);
    cmp("R9", "pc_we", pc_we, 1);
    cmp("R9", "fd_we", fd_we, 1);
  endtask

  task automatic t_sweep();
    logic [31:0] s;
    s = 32'h1234_5678;
    for (int i = 0; i < 600; i++) begin
      next_slot();
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      fd_rs1 = s[2:0]; fd_rs2 = s[5:3]; dx_rs1 = s[8:6]; dx_rs2 = s[11:9];
      dx_rd = s[14:12]; xm_rd = s[17:15]; xm_rs2 = s[20:18]; mw_rd = s[23:21];
      fd_is_store = s[24]; dx_wen = s[25] | s[26]; dx_is_load = s[27];
      xm_wen = s[28] | s[26]; xm_is_store = s[29]; mw_wen = s[30] | s[24];
      br_taken_x = s[31] & s[0];
      settle();
      check_all("R1 R2 R4 R5 R6 R9 sweep");
    end
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clear_inputs();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset_state();
    t_opnd_a_priority();
    t_opnd_b_indep();
    t_zero_reg();
    t_store_data();
    t_loaduse_rs1();
    t_loaduse_rs2();
    t_nonload();
    t_branch();
    t_sweep();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule